// File: doc/BRIEF.md
# Fractional Oversample Tick Generator

This block derives the 16x oversampling strobe for an asynchronous serial port from the system clock. Software programs one divider register. The register holds an unsigned field that sits above a group of ignored low bits. The lowest bit of that field is worth one quarter of an input clock. With a field value D, the strobe comes on average once every (4 + D) / 4 clocks. The resulting line rate is therefore 4 × f_clk / (16 × (4 + D)). D = 0 gives the fastest rate, f_clk / 16.

A quarter-clock phase accumulator produces the strobe. On each enabled cycle it adds 4, and it fires when the total reaches 4 + D. The remainder carries into the next period. Every individual strobe interval is the floor or the ceiling of the ideal fractional period, so no interval is off by a full clock. A register write resets the phase, so the new rate applies at once. Dropping the enable freezes the phase and suppresses the strobe. The register reads back with the programmed field in place, so software can recover the line rate.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, `tick` is 0 and `rd_data` is all zeros.
- R2: `rd_data` returns bits [20:6] of the last written word in their original positions. All other bits read as 0, and the value does not change without a write.
- R3: Bits [5:0] of a written word have no effect on strobe timing or on readback.
- R4: With field value D and L = 4 + D, counting enabled cycles c from 1 after a write, the strobe is high in the cycle after the c-th enabled edge exactly when floor(4c/L) > floor(4(c-1)/L).
- R5: With D = 0, the strobe is high after every enabled edge.
- R6: When D is a multiple of 4, strobes are evenly spaced D/4 + 1 enabled cycles apart.
- R7: A write clears the phase. The strobe is low in the cycle after the write edge, and the sequence of R4 restarts from c = 1.
- R8: While `en` is low, no strobe is produced and the phase is held. Counting in R4 resumes with the next enabled edge.
- R9: The largest field value is 32767. D = 32764 gives one strobe every 8192 clocks, which is the slowest standard setting.
- R10: For D ≥ 4, a strobe is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Advances the phase when high |
| wr_en | input | 1 | Divider register write strobe |
| wr_data | input | 32 | Divider register write word |
| rd_data | output | 32 | Divider register readback |
| tick | output | 1 | One-cycle oversample strobe |

## Verification
The bench uses the default parameters: a 32-bit register, the field starting at bit 6, a 15-bit field and two fractional bits. These values reach the fastest setting, the full-scale field and the slowest standard setting of 8192 clocks per strobe. Several fractional field values are compared cycle by cycle against the floor-difference formula. The comparison covers continuous enable, a gapped enable pattern, and a rewrite in the middle of a stream.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
   localparam int DEF_REG_W     = 32;
   localparam int DEF_FIELD_LSB = 6;
   localparam int DEF_DIV_W     = 15;
   localparam int DEF_FRAC_BITS = 2;
endpackage

// File: rtl/frac_div_reg.sv
module frac_div_reg #(
   parameter int REG_W     = 32,
   parameter int FIELD_LSB = 6,
   parameter int DIV_W     = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [DIV_W-1:0] div_field,
   output logic [REG_W-1:0] rd_data
);
   localparam int FIELD_MSB = FIELD_LSB + DIV_W - 1;
   localparam int UPPER_W   = REG_W - FIELD_MSB - 1;

   if (FIELD_MSB >= REG_W) begin : g_bad_field
      $error("frac_div_reg: field does not fit the register");
   end

   logic [DIV_W-1:0] field_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     field_q <= '0;
      else if (wr_en) field_q <= wr_data[FIELD_MSB:FIELD_LSB];
   end

   assign div_field = field_q;

   // Readback packing: ignored low bits and unused upper bits read as zero.
   if (FIELD_LSB > 0 && UPPER_W > 0) begin : g_pad_both
      assign rd_data = {{UPPER_W{1'b0}}, field_q, {FIELD_LSB{1'b0}}};
   end else if (FIELD_LSB > 0) begin : g_pad_low
      assign rd_data = {field_q, {FIELD_LSB{1'b0}}};
   end else if (UPPER_W > 0) begin : g_pad_high
      assign rd_data = {{UPPER_W{1'b0}}, field_q};
   end else begin : g_pad_none
      assign rd_data = field_q;
   end

   // R2: readback only moves on a write
   a_r2_readback_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
   parameter int DIV_W     = 15,
   parameter int FRAC_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [DIV_W-1:0] div_field,
   output logic             tick
);
   localparam int STEP  = 1 << FRAC_BITS;
   localparam int ACC_W = DIV_W + 2;

   if (FRAC_BITS < 0 || FRAC_BITS > 8) begin : g_bad_frac
      $error("frac_phase_acc: FRAC_BITS out of range");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("frac_phase_acc: DIV_W must be positive");
   end

   logic [ACC_W-1:0] acc_q, acc_d, limit, sum;
   logic             hit, tick_q;

   assign limit = ACC_W'(STEP) + ACC_W'(div_field);
   assign sum   = acc_q + ACC_W'(STEP);
   assign hit   = en && !clr && (sum >= limit);

   always_comb begin
      acc_d = acc_q;
      if (clr)      acc_d = '0;
      else if (en)  acc_d = hit ? (sum - limit) : sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         acc_q  <= acc_d;
         tick_q <= hit;
      end
   end

   assign tick = tick_q;

   // R4: the carried remainder always stays below one period
   a_r4_phase_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < limit);
   // R7: a clear restarts the phase and kills the next strobe
   a_r7_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0) && !tick);
   // R8: disabled cycles hold the phase
   a_r8_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(acc_q) && !tick);
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
   parameter int REG_W     = frac_tick_pkg::DEF_REG_W,
   parameter int FIELD_LSB = frac_tick_pkg::DEF_FIELD_LSB,
   parameter int DIV_W     = frac_tick_pkg::DEF_DIV_W,
   parameter int FRAC_BITS = frac_tick_pkg::DEF_FRAC_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             tick
);
   localparam int STEP = 1 << FRAC_BITS;

   logic [DIV_W-1:0] div_field;

   frac_div_reg #(
      .REG_W     (REG_W),
      .FIELD_LSB (FIELD_LSB),
      .DIV_W     (DIV_W)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .div_field (div_field),
      .rd_data   (rd_data)
   );

   frac_phase_acc #(
      .DIV_W     (DIV_W),
      .FRAC_BITS (FRAC_BITS)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .clr       (wr_en),
      .div_field (div_field),
      .tick      (tick)
   );

   // R5: zero divider strobes on every enabled edge
   a_r5_fastest: assert property (@(posedge clk) disable iff (!rst_n)
      (div_field == '0 && en && !wr_en) |=> tick);
   // R8: a strobe needs an enabled, write-free edge
   a_r8_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(en) && !$past(wr_en));
   // R10: no back-to-back strobes once the period is at least two clocks
   a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && 32'(div_field) >= STEP) |=> !tick);
endmodule

// File: tb/frac_tick_gen_bench.sv
module frac_tick_gen_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        tick;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_tick_gen u_frac_tick_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_tick(input int c, input int d);
      int l = 4 + d;
      return ((4 * c) / l) != ((4 * (c - 1)) / l);
   endfunction

   // write at one edge; returns sampled at the following negedge
   task automatic do_write(input logic [31:0] data);
      wr_en = 1'b1; wr_data = data;
      @(posedge clk); #1;
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   // run n cycles after a write, compare strobe per cycle with the formula
   // gap=0: enable always on; gap>0: enable low every gap-th cycle
   task automatic run_stream(input string req, input int d, input int n, input int gap);
      int cnt = 0;
      int bad = 0;
      logic act_first = 1'b0, exp_first = 1'b0;
      for (int k = 1; k <= n; k++) begin
         logic e = (gap == 0) ? 1'b1 : ((k % gap) != 0);
         logic x;
         en = e;
         @(negedge clk);
         if (e) begin cnt++; x = exp_tick(cnt, d); end
         else x = 1'b0;
         if (tick !== x && bad == 0) begin act_first = tick; exp_first = x; end
         if (tick !== x) bad++;
      end
      en = 1'b0;
      checks++;
      if (bad != 0) begin
         failures++;
         $display("FAIL %s D=%0d mismatches=%0d actual=%0b expected=%0b", req, d, bad, act_first, exp_first);
      end
   endtask

   task automatic t_reset();
      check("R1 tick", {31'b0, tick}, 32'h0);
      check("R1 rd_data", rd_data, 32'h0);
   endtask

   task automatic t_readback();
      do_write(32'hFFFF_FFFF);
      check("R2 all ones", rd_data, 32'h001F_FFC0);
      do_write(32'h0000_1234 << 6 | 32'h3F);
      check("R2 R3 low bits dropped", rd_data, 32'h0000_1234 << 6);
      en = 1'b1; repeat (5) @(negedge clk); en = 1'b0;
      check("R2 stable without write", rd_data, 32'h0000_1234 << 6);
   endtask

   task automatic t_write_clear();
      do_write(32'd0 << 6);
      check("R7 no tick after write", {31'b0, tick}, 32'h0);
      run_stream("R5 fastest", 0, 20, 0);
      do_write(32'd13 << 6);
      check("R7 cleared tick", {31'b0, tick}, 32'h0);
      run_stream("R4 D=13", 13, 60, 0);
      do_write((32'd13 << 6) | 32'h2A);
      run_stream("R3 R7 low bits ignored restart", 13, 60, 0);
   endtask

   task automatic t_fractions();
      do_write(32'd1 << 6);  run_stream("R4 D=1", 1, 40, 0);
      do_write(32'd6 << 6);  run_stream("R4 D=6", 6, 50, 0);
      do_write(32'd8 << 6);  run_stream("R6 D=8", 8, 40, 0);
      do_write(32'd7 << 6);  run_stream("R8 gapped enable", 7, 90, 3);
      do_write(32'd2 << 6);  run_stream("R8 gapped enable D=2", 2, 40, 4);
   endtask

   task automatic t_limits();
      do_write(32'd32767 << 6);
      check("R9 max field readback", rd_data, 32'd32767 << 6);
      run_stream("R9 D=32767", 32767, 8200, 0);
      do_write(32'd32764 << 6);
      run_stream("R9 R6 slowest", 32764, 16400, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_write_clear();
      t_fractions();
      t_limits();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin repeat (150000) @(posedge clk); end
      join_any
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule